// File: doc/BRIEF.md
# Cascadable Display Command Receiver

This block is the write-only serial front end of a segment display driver that is built to be chained. It listens on an I2C bus as a slave receiver and finds START and STOP conditions. It matches the slave address, using one strap input to choose between two addresses. It acknowledges the bytes it accepts. After the address come one or more command bytes. Each command is presented on a one-cycle strobe. Display data bytes then follow, and each is turned into a write on a display-memory port.

Up to sixteen identical devices can share the bus: two clusters of eight, one per address. Every device in a cluster receives the same stream. Each device keeps its own copy of a memory pointer and of a subaddress counter, and all copies advance in step after every data byte. A device stores and acknowledges a data byte only when the subaddress counter equals its own 3-bit strap code. When the pointer passes the last memory location, the subaddress counter steps, so a long stream runs across the chain one device after another. The block drives SDA only to pull it low for an acknowledge.

Top module: `lcd_cmd_rx`

## Requirements
- R1: After reset, `sda_oe_o`, `wr_en_o` and `cmd_valid_o` are low, the receiver is idle, and the pointer and the subaddress counter are zero.
- R2: After a START, the first byte is acknowledged only when it equals {`BASE_ADDR`[5:0], `addr_sel_i`, 0}, with the default base being 6'b011100. On any mismatch of the base or of the select bit, no ack is given, and the bytes up to the next START produce no ack, no command and no write.
- R3: An address byte whose bit 0 (read flag) is 1 is not acknowledged, and the rest of the transfer is ignored.
- R4: Every command byte after a matching address is acknowledged and is presented for one cycle on `cmd_byte_o` with `cmd_valid_o`. If bit 7 of the byte is 1, another command follows; if it is 0, display data follows.
- R5: A command with bit 6 = 0 loads the pointer from bits 5:0, and a value of `DEPTH` or more loads 0. A command with bit 6 = 1 loads the subaddress counter from bits 2:0.
- R6: A display data byte is acknowledged and written (`wr_en_o` for one cycle, `wr_addr_o` = pointer, `wr_data_o` = byte) only when the subaddress counter equals `dev_id_i`. Otherwise it is neither acknowledged nor written.
- R7: The pointer advances after every data byte, whether the byte matched or not. From `DEPTH`-1 it wraps to 0, and the subaddress counter then increments modulo 8. Both values persist across transfers.
- R8: `sda_oe_o` rises only after the SCL fall that ends the eighth bit of an accepted byte. It falls at the next SCL fall, so it is never high while a data bit is clocked.
- R9: A repeated START discards a partial byte and expects a new address. After a STOP, clocked bytes are ignored until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_sel_i | input | 1 | Cluster select, bit 1 of the slave address |
| dev_id_i | input | 3 | Hardware subaddress of this device within its cluster |
| sda_oe_o | output | 1 | Pull SDA low (acknowledge) |
| cmd_valid_o | output | 1 | One-cycle strobe for a received command byte |
| cmd_byte_o | output | 8 | Received command byte |
| wr_en_o | output | 1 | One-cycle display-memory write strobe |
| wr_addr_o | output | 6 | Display-memory write address |
| wr_data_o | output | 8 | Display-memory write data |

## Verification
Every bus pin change passes two synchroniser stages and one edge register. The acknowledge drive, the command strobe and the write strobe therefore all appear on the third clock edge after the SCL fall that ends a byte. The bench holds each SCL phase for six clocks. It samples the acknowledge in the middle of the SCL-high period that follows, so the result is settled, and it samples `sda_oe_o` in each data bit's high phase to confirm that the line is released. Strobes are compared on every falling clock edge against queues filled by a behavioural model of pointer and subaddress stepping. Each strobe must match the head of its queue, and both queues must be empty at the end.

// File: rtl/lcdrx_pkg.sv
package lcdrx_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_CMD,
        PH_DATA,
        PH_SKIP
    } phase_e;

    localparam int BYTE_BITS = 8;
    localparam logic [5:0] DEFAULT_BASE = 6'b011100;
endpackage

// File: rtl/lcdrx_sync.sv
module lcdrx_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg_q[s] <= '1;
                    else        stg_q[s] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg_q[s] <= '1;
                    else        stg_q[s] <= stg_q[s-1];
                end
            end
        end
    endgenerate

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/lcdrx_cond.sv
module lcdrx_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_c,
    output logic stop_c
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise = scl_s & ~scl_q;
    assign scl_fall = ~scl_s & scl_q;
    assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/lcd_cmd_rx.sv
module lcd_cmd_rx
    import lcdrx_pkg::*;
#(
    parameter int         DEPTH     = 40,
    parameter int         SUB_W     = 3,
    parameter logic [5:0] BASE_ADDR = DEFAULT_BASE,
    localparam int        PTR_W     = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic             addr_sel_i,
    input  logic [SUB_W-1:0] dev_id_i,
    output logic             sda_oe_o,
    output logic             cmd_valid_o,
    output logic [7:0]       cmd_byte_o,
    output logic             wr_en_o,
    output logic [PTR_W-1:0] wr_addr_o,
    output logic [7:0]       wr_data_o
);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [6:0]       DEPTH_7  = 7'(DEPTH);

    typedef struct packed {
        phase_e           phase;
        logic [7:0]       shreg;
        logic [3:0]       bits;
        logic             in_ack;
        logic             oe;
        logic [PTR_W-1:0] ptr;
        logic [SUB_W-1:0] sub;
        logic             cmd_v;
        logic [7:0]       cmd_b;
        logic             wr_v;
        logic [PTR_W-1:0] wr_a;
        logic [7:0]       wr_d;
    } state_t;

    state_t st_d, st_q;

    logic scl_s, sda_s;
    logic scl_rise, scl_fall, start_c, stop_c;

    lcdrx_sync #(.W(2), .STAGES(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({scl_i, sda_i}),
        .dout ({scl_s, sda_s})
    );

    lcdrx_cond u_cond (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_s   (scl_s),
        .sda_s   (sda_s),
        .scl_rise(scl_rise),
        .scl_fall(scl_fall),
        .start_c (start_c),
        .stop_c  (stop_c)
    );

    // Byte complete: decide acknowledge and side effects per phase
    always_comb begin
        st_d       = st_q;
        st_d.cmd_v = 1'b0;
        st_d.wr_v  = 1'b0;
        if (start_c) begin
            st_d.phase  = PH_ADDR;
            st_d.bits   = '0;
            st_d.in_ack = 1'b0;
            st_d.oe     = 1'b0;
        end else if (stop_c) begin
            st_d.phase  = PH_IDLE;
            st_d.bits   = '0;
            st_d.in_ack = 1'b0;
            st_d.oe     = 1'b0;
        end else if (st_q.phase != PH_IDLE) begin
            if (scl_rise && !st_q.in_ack && st_q.bits != 4'(BYTE_BITS)) begin
                st_d.shreg = {st_q.shreg[6:0], sda_s};
                st_d.bits  = st_q.bits + 4'd1;
            end
            if (scl_fall) begin
                if (st_q.in_ack) begin
                    st_d.in_ack = 1'b0;
                    st_d.oe     = 1'b0;
                end else if (st_q.bits == 4'(BYTE_BITS)) begin
                    st_d.in_ack = 1'b1;
                    st_d.bits   = '0;
                    case (st_q.phase)
                        PH_ADDR: begin
                            if (st_q.shreg == {BASE_ADDR, addr_sel_i, 1'b0}) begin
                                st_d.oe    = 1'b1;
                                st_d.phase = PH_CMD;
                            end else begin
                                st_d.phase = PH_SKIP;
                            end
                        end
                        PH_CMD: begin
                            st_d.oe    = 1'b1;
                            st_d.cmd_v = 1'b1;
                            st_d.cmd_b = st_q.shreg;
                            if (!st_q.shreg[6]) begin
                                st_d.ptr = ({1'b0, st_q.shreg[5:0]} < DEPTH_7)
                                         ? st_q.shreg[PTR_W-1:0] : '0;
                            end else begin
                                st_d.sub = st_q.shreg[SUB_W-1:0];
                            end
                            st_d.phase = st_q.shreg[7] ? PH_CMD : PH_DATA;
                        end
                        PH_DATA: begin
                            st_d.oe   = (st_q.sub == dev_id_i);
                            st_d.wr_v = (st_q.sub == dev_id_i);
                            st_d.wr_a = st_q.ptr;
                            st_d.wr_d = st_q.shreg;
                            if (st_q.ptr == LAST_PTR) begin
                                st_d.ptr = '0;
                                st_d.sub = st_q.sub + 1'b1;
                            end else begin
                                st_d.ptr = st_q.ptr + 1'b1;
                            end
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    logic [SUB_W-1:0] sub_cnt;
    logic [PTR_W-1:0] ptr_cnt;
    assign sub_cnt     = st_q.sub;
    assign ptr_cnt     = st_q.ptr;
    assign sda_oe_o    = st_q.oe;
    assign cmd_valid_o = st_q.cmd_v;
    assign cmd_byte_o  = st_q.cmd_b;
    assign wr_en_o     = st_q.wr_v;
    assign wr_addr_o   = st_q.wr_a;
    assign wr_data_o   = st_q.wr_d;
endmodule

// File: rtl/lcd_cmd_rx_chk.sv
module lcd_cmd_rx_chk #(
    parameter int DEPTH = 40,
    parameter int SUB_W = 3,
    parameter int PTR_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_i,
    input logic             sda_oe_o,
    input logic             cmd_valid_o,
    input logic             wr_en_o,
    input logic [PTR_W-1:0] wr_addr_o,
    input logic [SUB_W-1:0] dev_id_i,
    input logic [SUB_W-1:0] sub_cnt,
    input logic [PTR_W-1:0] ptr_cnt
);
    localparam logic [PTR_W:0]   DEPTH_X = (PTR_W+1)'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_P  = PTR_W'(DEPTH - 1);

    a_r6_write_acked: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> sda_oe_o);

    a_r6_write_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |=> !wr_en_o);

    a_r6_write_matches_id: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && wr_addr_o != LAST_P) |-> (sub_cnt == dev_id_i));

    a_r4_cmd_acked: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> sda_oe_o);

    a_r4_cmd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |=> !cmd_valid_o);

    a_r4_no_cmd_with_write: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid_o && wr_en_o));

    a_r8_ack_starts_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !scl_i);

    a_r7_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, ptr_cnt} < DEPTH_X);

    a_r7_write_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> ({1'b0, wr_addr_o} < DEPTH_X));
endmodule

bind lcd_cmd_rx lcd_cmd_rx_chk #(.DEPTH(DEPTH), .SUB_W(SUB_W), .PTR_W(PTR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_oe_o   (sda_oe_o),
    .cmd_valid_o(cmd_valid_o),
    .wr_en_o    (wr_en_o),
    .wr_addr_o  (wr_addr_o),
    .dev_id_i   (dev_id_i),
    .sub_cnt    (sub_cnt),
    .ptr_cnt    (ptr_cnt)
);

// File: tb/lcd_cmd_rx_test.sv
module lcd_cmd_rx_test;
    localparam int DEPTH = 40;
    localparam int Q     = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sel = 1'b0;
    logic [2:0] dev = 3'd0;
    logic       sda_oe, cmd_v, wr_en;
    logic [7:0] cmd_b, wr_d;
    logic [5:0] wr_a;
    logic       sda_bus;

    assign sda_bus = m_sda & ~sda_oe;

    always #2 clk = ~clk;

    lcd_cmd_rx uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (sda_bus),
        .addr_sel_i (sel),
        .dev_id_i   (dev),
        .sda_oe_o   (sda_oe),
        .cmd_valid_o(cmd_v),
        .cmd_byte_o (cmd_b),
        .wr_en_o    (wr_en),
        .wr_addr_o  (wr_a),
        .wr_data_o  (wr_d)
    );

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 0;

    // reference model state
    int m_phase = 0;   // 0 idle, 1 address, 2 command, 3 data, 4 skip
    int m_ptr   = 0;
    int m_sub   = 0;
    int wq_a[$];
    int wq_d[$];
    int cq[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // strobe comparison and watchdog on every falling clock edge
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            chk(1'b0, "R9", "watchdog expired", cyc, 150000);
            done = 1;
            finish_run();
        end
        if (rst_n && wr_en) begin
            if (wq_a.size() == 0) begin
                chk(1'b0, "R6", "unexpected write at addr", int'(wr_a), -1);
            end else begin
                int ea, ed;
                ea = wq_a.pop_front();
                ed = wq_d.pop_front();
                chk(int'(wr_a) == ea, "R6", "write address", int'(wr_a), ea);
                chk(int'(wr_d) == ed, "R6", "write data", int'(wr_d), ed);
            end
        end
        if (rst_n && cmd_v) begin
            if (cq.size() == 0) begin
                chk(1'b0, "R4", "unexpected command", int'(cmd_b), -1);
            end else begin
                int ec;
                ec = cq.pop_front();
                chk(int'(cmd_b) == ec, "R4", "command byte", int'(cmd_b), ec);
            end
        end
    end

    task automatic wq_();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq_();
        scl = 1'b1;   wq_();
        m_sda = 1'b0; wq_();
        scl = 1'b0;   wq_();
        m_phase = 1;
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq_();
        scl = 1'b1;   wq_();
        m_sda = 1'b1; wq_();
        m_phase = 0;
    endtask

    task automatic put_bits(input logic [7:0] b, input int n, output bit seen);
        seen = 0;
        for (int i = 7; i > 7 - n; i--) begin
            m_sda = b[i]; wq_();
            scl = 1'b1;   wq_();
            if (sda_oe) seen = 1;
            wq_();
            scl = 1'b0;   wq_();
        end
    endtask

    task automatic put_byte(input logic [7:0] b, input string req);
        bit exp_ack, seen, got;
        exp_ack = 0;
        case (m_phase)
            1: begin
                if (b == {6'b011100, sel, 1'b0}) begin
                    exp_ack = 1; m_phase = 2;
                end else begin
                    m_phase = 4;
                end
            end
            2: begin
                exp_ack = 1;
                cq.push_back(int'(b));
                if (!b[6]) m_ptr = (int'(b[5:0]) < DEPTH) ? int'(b[5:0]) : 0;
                else       m_sub = int'(b[2:0]);
                m_phase = b[7] ? 2 : 3;
            end
            3: begin
                exp_ack = (m_sub == int'(dev));
                if (exp_ack) begin
                    wq_a.push_back(m_ptr);
                    wq_d.push_back(int'(b));
                end
                if (m_ptr == DEPTH - 1) begin
                    m_ptr = 0; m_sub = (m_sub + 1) % 8;
                end else begin
                    m_ptr++;
                end
            end
            default: ;
        endcase
        put_bits(b, 8, seen);
        chk(!seen, "R8", "ack line during data bits", int'(seen), 0);
        m_sda = 1'b1; wq_();
        scl = 1'b1;   wq_();
        got = sda_oe;
        chk(got == exp_ack, req, $sformatf("ack for byte %02h", b), int'(got), int'(exp_ack));
        wq_();
        scl = 1'b0;   wq_();
    endtask

    initial begin
        bit seen;
        repeat (5) @(negedge clk);
        // R1: reset state
        chk(!sda_oe, "R1", "sda_oe in reset", int'(sda_oe), 0);
        chk(!wr_en && !cmd_v, "R1", "strobes in reset", int'(wr_en) + int'(cmd_v), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(!sda_oe, "R1", "sda_oe after reset", int'(sda_oe), 0);

        // R2/R4/R6: basic stream to device 0
        bus_start();
        put_byte(8'h70, "R2");
        put_byte(8'hC0, "R4");   // subaddress 0, another command follows
        put_byte(8'h05, "R5");   // pointer 5, data follows
        put_byte(8'hA1, "R6");
        put_byte(8'hB2, "R6");
        put_byte(8'hC3, "R6");
        bus_stop();

        // R2: select bit mismatch, whole transfer ignored
        sel = 1'b1;
        bus_start();
        put_byte(8'h70, "R2");
        put_byte(8'h00, "R2");
        put_byte(8'h55, "R2");
        bus_stop();
        bus_start();
        put_byte(8'h72, "R2");
        put_byte(8'h00, "R5");
        put_byte(8'h11, "R6");
        bus_stop();
        sel = 1'b0;

        // R3: read request refused
        bus_start();
        put_byte(8'h71, "R3");
        put_byte(8'h00, "R3");
        bus_stop();

        // R5/R6/R7: subaddress match and wrap across pointer end
        dev = 3'd2;
        bus_start();
        put_byte(8'h70, "R2");
        put_byte(8'hC1, "R5");
        put_byte(8'h26, "R5");
        put_byte(8'h10, "R7");
        put_byte(8'h20, "R7");
        put_byte(8'h30, "R7");
        put_byte(8'h31, "R7");
        bus_stop();

        // R5: pointer load beyond depth gives 0
        bus_start();
        put_byte(8'h70, "R2");
        put_byte(8'h30, "R5");
        put_byte(8'h77, "R5");
        bus_stop();

        // R9: repeated START mid-byte
        bus_start();
        put_byte(8'h70, "R2");
        put_byte(8'h03, "R5");
        put_bits(8'hFF, 4, seen);
        chk(!seen, "R9", "ack line during partial byte", int'(seen), 0);
        bus_start();
        put_byte(8'h70, "R9");
        put_byte(8'h04, "R9");
        put_byte(8'h9A, "R9");
        bus_stop();

        // R9: bytes after STOP with no START
        scl = 1'b0; wq_();
        put_byte(8'h55, "R9");
        m_sda = 1'b1; wq_();
        scl = 1'b1;   wq_();

        repeat (20) @(negedge clk);
        chk(wq_a.size() == 0, "R6", "missing writes", wq_a.size(), 0);
        chk(cq.size() == 0, "R4", "missing commands", cq.size(), 0);
        done = 1;
        finish_run();
    end
endmodule